// File: doc/BRIEF.md
# Infrared Run-Length Sampler

This block watches the output of an infrared receiver diode and turns its waveform into a stream of run-length bytes. Each byte gives the line level of one run, mark or space, and how many sample ticks the run lasted. The input may be inverted and is then passed through a programmable glitch filter. Bytes go into a receive queue that software pops through a small register interface. Software decodes the remote-control protocol from those bytes.

A packet opens when a mark has lasted an active threshold. The ticks of that threshold are not recorded, so the decoder adds them back to the first mark. The packet closes once the line has stayed at space for a programmable idle time. The block raises an interrupt for three events: a packet end, a queue fill above a trigger level, and a byte lost to a full queue. Each event can be masked on its own.

Top module: `cir_rx_sampler`

## Requirements
- R1: The sample tick is one per 64 clocks when sampling-config bit 0 is 0, and one per 128 clocks when it is 1.
- R2: Each queued byte holds the run level in bit 7 (1 = mark, 0 = space) and the tick count minus one in bits 6:0. A run longer than 128 ticks gives one 0x7F-length byte per full 128 ticks, then one byte for the remainder. A remainder of zero gives no byte.
- R3: A level change shorter than the filter threshold (sampling-config bits 7:2, in ticks) is ignored. The run around it is measured as one unbroken run.
- R4: While waiting, a mark must last T ticks before recording starts, with T = (sampling-config bits 22:16) + 1. T is multiplied by 128 when bit 23 is set. Those T ticks are not recorded, and a shorter mark leaves no trace.
- R5: After a packet has opened, a space of (N+1)x128 ticks ends it, with N = sampling-config bits 15:8. The whole space is queued as N+1 bytes of 0x7F. Status bit 1 then sets and the block waits for a new activation.
- R6: When receive-config bit 2 is 1, the input is inverted before sampling.
- R7: Reading the data register (address 2) pops bytes in arrival order. Status bits from 8 upward hold the number of queued bytes.
- R8: A byte pushed into a full queue is dropped and status bit 0 sets.
- R9: Status bit 4 sets while the fill count exceeds the trigger level (interrupt-enable bits from 8 upward).
- R10: Writing 1 to status bits 0, 1 or 4 clears that flag. Writing 0 leaves it unchanged.
- R11: irq is high exactly when a status flag is set and its enable bit is set (enable bits 0, 1 and 4).
- R12: The receiver runs only when control bit 0, control bit 1 and both control bits 5:4 are 1. Otherwise the input is ignored.
- R13: After reset all registers, flags and the queue are zero and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 1 | Raw receiver line |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; pops the queue at address 2 |
| reg_addr | input | 3 | Register address: 0 control, 1 receive config, 2 data, 3 interrupt enable, 4 status, 5 sampling config |
| reg_wdata | input | 24 | Write data |
| reg_rdata | output | 24 | Read data, valid the cycle after reg_rd |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives waveforms of known tick lengths and builds the expected byte list arithmetically, splitting each run into 128-tick chunks. It aims at the chunk boundary: a design that emits a zero-length byte, or resets the level after saturation, shows up on a 304-tick mark. It also aims at glitches and sub-threshold marks: a design without the filter splits one mark into three, and one that records the activation ticks reports marks that are too long. Three more cases are covered. A design with the wrong divider produces doubled lengths in 128-clock mode. One that cannot drop on a full queue either corrupts data or misses the overflow flag. One that ignores the mode bits fills the queue while it is disabled.

// File: rtl/cir_pkg.sv
package cir_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned REG_W  = 24;
  localparam int unsigned LEN_W  = 7;
  localparam int unsigned TICK_W = 16;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_RXCFG = 3'd1;
  localparam logic [ADDR_W-1:0] A_DATA  = 3'd2;
  localparam logic [ADDR_W-1:0] A_IEN   = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd4;
  localparam logic [ADDR_W-1:0] A_SCFG  = 3'd5;

  // flag bit positions in status and enable registers
  localparam int unsigned B_OVF   = 0;
  localparam int unsigned B_PEND  = 1;
  localparam int unsigned B_AVAIL = 4;
  localparam int unsigned B_LEVEL = 8;

  // ticks a mark must last before a packet opens
  function automatic logic [TICK_W-1:0] active_ticks(input logic [6:0] fld, input logic x128);
    logic [TICK_W-1:0] base;
    base = {{(TICK_W-7){1'b0}}, fld} + 1'b1;
    return x128 ? (base << 7) : base;
  endfunction

  // ticks of space that close a packet
  function automatic logic [TICK_W-1:0] idle_ticks(input logic [7:0] n);
    return ({{(TICK_W-8){1'b0}}, n} + 1'b1) << 7;
  endfunction

  function automatic logic [7:0] pack_run(input logic lvl, input logic [LEN_W-1:0] len_m1);
    return {lvl, len_m1};
  endfunction
endpackage

// File: rtl/cir_tick_gen.sv
module cir_tick_gen #(
  parameter int unsigned SLOW_DIV = 128,
  parameter int unsigned FAST_DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic div_slow,
  output logic tick
);
  localparam int unsigned CW = $clog2(SLOW_DIV);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last = div_slow ? CW'(SLOW_DIV - 1) : CW'(FAST_DIV - 1);
  assign tick = run && (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (!run || cnt_q >= last) cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cir_glitch_filter.sv
module cir_glitch_filter #(
  parameter int unsigned FW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic          lvl_in,
  input  logic [FW-1:0] thr,
  output logic          lvl_o,
  output logic          stb_o
);
  logic [FW-1:0] dis_q;
  logic [FW:0]   dis_inc;

  assign dis_inc = {1'b0, dis_q} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_o <= 1'b0;
      stb_o <= 1'b0;
      dis_q <= '0;
    end else if (!run) begin
      lvl_o <= 1'b0;
      stb_o <= 1'b0;
      dis_q <= '0;
    end else begin
      stb_o <= tick;
      if (tick) begin
        if (lvl_in == lvl_o) begin
          dis_q <= '0;
        end else if (dis_inc >= {1'b0, thr}) begin
          lvl_o <= lvl_in;
          dis_q <= '0;
        end else begin
          dis_q <= dis_inc[FW-1:0];
        end
      end
    end
  end

  // a filtered edge may only follow a sampling tick
  assert_edge_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && lvl_o != $past(lvl_o)) |-> $past(tick));
endmodule

// File: rtl/cir_run_meter.sv
module cir_run_meter import cir_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              stb,
  input  logic              lvl,
  input  logic [TICK_W-1:0] act_lim,
  input  logic [TICK_W-1:0] idle_lim,
  output logic              emit,
  output logic [7:0]        run_byte,
  output logic              pkt_end
);
  localparam logic [LEN_W-1:0] MAXC = '1;

  logic              active_q, active_n;
  logic              rlvl_q, rlvl_n;
  logic [LEN_W-1:0]  cnt_q, cnt_n;
  logic [TICK_W-1:0] acc_q, acc_n;

  always_comb begin
    emit     = 1'b0;
    run_byte = 8'h00;
    pkt_end  = 1'b0;
    active_n = active_q;
    rlvl_n   = rlvl_q;
    cnt_n    = cnt_q;
    acc_n    = acc_q;
    if (stb) begin
      if (!active_q) begin
        if (lvl) begin
          if (acc_q + 1'b1 >= act_lim) begin
            active_n = 1'b1;
            rlvl_n   = 1'b1;
            cnt_n    = '0;
            acc_n    = '0;
          end else begin
            acc_n = acc_q + 1'b1;
          end
        end else begin
          acc_n = '0;
        end
      end else if (lvl == rlvl_q) begin
        if (cnt_q == MAXC) begin
          emit     = 1'b1;
          run_byte = pack_run(rlvl_q, MAXC);
          cnt_n    = '0;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
        if (!rlvl_q) begin
          if (acc_q + 1'b1 >= idle_lim) begin
            pkt_end  = 1'b1;
            active_n = 1'b0;
            acc_n    = '0;
            cnt_n    = '0;
          end else begin
            acc_n = acc_q + 1'b1;
          end
        end
      end else begin
        if (cnt_q != '0) begin
          emit     = 1'b1;
          run_byte = pack_run(rlvl_q, cnt_q - 1'b1);
        end
        rlvl_n = lvl;
        cnt_n  = LEN_W'(1);
        acc_n  = lvl ? '0 : TICK_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rlvl_q   <= 1'b0;
      cnt_q    <= '0;
      acc_q    <= '0;
    end else if (!run) begin
      active_q <= 1'b0;
      rlvl_q   <= 1'b0;
      cnt_q    <= '0;
      acc_q    <= '0;
    end else begin
      active_q <= active_n;
      rlvl_q   <= rlvl_n;
      cnt_q    <= cnt_n;
      acc_q    <= acc_n;
    end
  end

  // a short (non-saturated) byte only appears where the filtered level flips
  assert_short_at_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && run_byte[LEN_W-1:0] != MAXC) |-> (lvl != run_byte[7]));
  // the packet closes only while the filtered line is at space
  assert_end_on_space_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |-> !lvl);
endmodule

// File: rtl/cir_fifo.sv
module cir_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       drop
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic          full, push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && (count != '0);
  assign drop    = push && full;
  assign dout    = (count != '0) ? mem[rp_q] : '0;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (pop_ok)  rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_full_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (count == $past(count)));
endmodule

// File: rtl/cir_rx_sampler.sv
module cir_rx_sampler import cir_pkg::*; #(
  parameter int unsigned FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ir_in,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq
);
  localparam int unsigned LW = $clog2(FIFO_DEPTH);
  localparam int unsigned CW = LW + 1;

  logic [5:0]       ctrl_q;
  logic             inv_q;
  logic [REG_W-1:0] scfg_q;
  logic [2:0]       en_q;    // {avail, pend, ovf}
  logic [2:0]       flag_q;  // {avail, pend, ovf}
  logic [LW-1:0]    trig_q;
  logic [1:0]       sync_q;

  logic             run, tick, flt_lvl, flt_stb;
  logic             emit, pkt_end, drop, avail_now, pop;
  logic [7:0]       run_byte, fifo_dout;
  logic [CW-1:0]    count;
  logic [2:0]       clr;
  logic [REG_W-1:0] rd_mux;

  assign run = ctrl_q[0] && ctrl_q[1] && (ctrl_q[5:4] == 2'b11);
  assign pop = reg_rd && (reg_addr == A_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], ir_in ^ inv_q};
  end

  cir_tick_gen u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .div_slow(scfg_q[0]), .tick(tick)
  );

  cir_glitch_filter #(.FW(6)) u_filt (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .lvl_in(sync_q[1]),
    .thr(scfg_q[7:2]), .lvl_o(flt_lvl), .stb_o(flt_stb)
  );

  cir_run_meter u_meter (
    .clk(clk), .rst_n(rst_n), .run(run), .stb(flt_stb), .lvl(flt_lvl),
    .act_lim(active_ticks(scfg_q[22:16], scfg_q[23])),
    .idle_lim(idle_ticks(scfg_q[15:8])),
    .emit(emit), .run_byte(run_byte), .pkt_end(pkt_end)
  );

  cir_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(emit), .din(run_byte), .pop(pop),
    .dout(fifo_dout), .count(count), .drop(drop)
  );

  assign avail_now = count > {1'b0, trig_q};
  assign clr = (reg_wr && reg_addr == A_STAT)
             ? {reg_wdata[B_AVAIL], reg_wdata[B_PEND], reg_wdata[B_OVF]} : 3'b000;
  assign irq = |(flag_q & en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      inv_q  <= 1'b0;
      scfg_q <= '0;
      en_q   <= '0;
      trig_q <= '0;
      flag_q <= '0;
    end else begin
      if (reg_wr && reg_addr == A_CTRL)  ctrl_q <= reg_wdata[5:0];
      if (reg_wr && reg_addr == A_RXCFG) inv_q  <= reg_wdata[2];
      if (reg_wr && reg_addr == A_SCFG)  scfg_q <= reg_wdata;
      if (reg_wr && reg_addr == A_IEN) begin
        en_q   <= {reg_wdata[B_AVAIL], reg_wdata[B_PEND], reg_wdata[B_OVF]};
        trig_q <= reg_wdata[B_LEVEL +: LW];
      end
      flag_q <= (flag_q & ~clr) | {avail_now, pkt_end, drop};
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_CTRL:  rd_mux[5:0] = ctrl_q;
      A_RXCFG: rd_mux[2]   = inv_q;
      A_DATA:  rd_mux[7:0] = fifo_dout;
      A_IEN: begin
        rd_mux[B_OVF]         = en_q[0];
        rd_mux[B_PEND]        = en_q[1];
        rd_mux[B_AVAIL]       = en_q[2];
        rd_mux[B_LEVEL +: LW] = trig_q;
      end
      A_STAT: begin
        rd_mux[B_OVF]         = flag_q[0];
        rd_mux[B_PEND]        = flag_q[1];
        rd_mux[B_AVAIL]       = flag_q[2];
        rd_mux[B_LEVEL +: CW] = count;
      end
      A_SCFG:  rd_mux = scfg_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  assert_quiet_when_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !emit);
  assert_ovf_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> flag_q[0]);
  assert_pend_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[1]) |-> $past(pkt_end));
  assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_STAT && reg_wdata[B_PEND] && !pkt_end) |=> !flag_q[1]);
endmodule

// File: tb/tb_cir_rx_sampler.sv
module tb_cir_rx_sampler;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ir_in = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [23:0] reg_wdata = '0;
  logic [23:0] reg_rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  int div = 64;
  bit done = 0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  cir_rx_sampler #(.FIFO_DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [23:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [23:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic hold(input logic v, input int ticks);
    ir_in = v;
    repeat (ticks * div) @(negedge clk);
  endtask

  // expected bytes for one filtered run of the given length
  task automatic expect_run(input logic lvl, input int ticks);
    for (int k = 0; k < ticks / 128; k++) exp_q.push_back({lvl, 7'h7F});
    if (ticks % 128 != 0) exp_q.push_back({lvl, 7'(ticks % 128 - 1)});
  endtask

  function automatic logic [23:0] scfg(input bit slow, input int filt, input int idle,
                                       input int act, input bit x128);
    return {x128, 7'(act), 8'(idle), 6'(filt), 1'b0, slow};
  endfunction

  task automatic drain(input string tag);
    logic [23:0] d;
    int n;
    n = (exp_q.size() < DEPTH) ? exp_q.size() : DEPTH;
    rd(3'd4, d);
    check({tag, " count"}, 32'(d[12:8]), 32'(n));
    for (int i = 0; i < n; i++) begin
      rd(3'd2, d);
      check({tag, " byte"}, 32'(d[7:0]), 32'(exp_q[i]));
    end
    exp_q.delete();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [23:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    rd(3'd4, d); check("R13 status", 32'(d), 0);
    rd(3'd0, d); check("R13 control", 32'(d), 0);
    rd(3'd5, d); check("R13 sampling cfg", 32'(d), 0);
    check("R13 irq", 32'(irq), 0);

    // filter 2, idle 128 ticks, activation 4 ticks, 64-clock tick
    wr(3'd5, scfg(0, 2, 0, 3, 0));
    wr(3'd3, 24'h000312);
    wr(3'd0, 24'h000033);

    // R4 activation ticks dropped, R2 format, R5 idle end, R7 order
    hold(1, 10); hold(0, 5); hold(1, 7); hold(0, 132);
    expect_run(1, 6); expect_run(0, 5); expect_run(1, 7); expect_run(0, 128);
    rd(3'd4, d); check("R5 R9 flags after packet", 32'(d[4:0]), 32'h12);
    check("R11 irq with enabled flags", 32'(irq), 1);
    drain("R7 R2 R4 short packet");
    wr(3'd4, 24'h000013);
    rd(3'd4, d); check("R10 all cleared", 32'(d), 0);
    check("R11 irq low after clear", 32'(irq), 0);

    // R2 saturation across 128-tick chunks
    hold(1, 304); hold(0, 132);
    expect_run(1, 300); expect_run(0, 128);
    rd(3'd4, d); check("R5 pend after long mark", 32'(d[1]), 1);
    wr(3'd4, 24'h000002);
    rd(3'd4, d); check("R10 only pend cleared", 32'(d[4:0]), 32'h10);
    drain("R2 long mark");
    wr(3'd4, 24'h0000FF);

    // R3 glitches: idle blip ignored, short gap inside a mark ignored
    hold(1, 1); hold(0, 20);
    hold(1, 8); hold(0, 1); hold(1, 12); hold(0, 132);
    expect_run(1, 17); expect_run(0, 128);
    drain("R3 glitch filter");
    wr(3'd4, 24'h0000FF);

    // R4 mark below activation threshold leaves no trace
    hold(1, 3); hold(0, 20);
    rd(3'd4, d); check("R4 sub-threshold mark", 32'(d), 0);

    // R4 x128 multiplier: threshold 128 ticks
    wr(3'd5, scfg(0, 2, 0, 0, 1));
    hold(1, 130); hold(0, 132);
    expect_run(1, 2); expect_run(0, 128);
    drain("R4 x128 threshold");
    wr(3'd4, 24'h0000FF);

    // R1 128-clock tick
    wr(3'd5, scfg(1, 2, 0, 3, 0));
    div = 128;
    hold(1, 10); hold(0, 132);
    expect_run(1, 6); expect_run(0, 128);
    rd(3'd4, d); check("R9 no avail at two bytes", 32'(d[4:0]), 32'h02);
    drain("R1 slow tick");
    div = 64;
    wr(3'd5, scfg(0, 2, 0, 3, 0));
    wr(3'd4, 24'h0000FF);

    // R6 polarity invert: idle line high, mark is low
    wr(3'd0, 24'h0);
    wr(3'd1, 24'h000004);
    ir_in = 1'b1;
    repeat (4) @(negedge clk);
    wr(3'd0, 24'h000033);
    hold(0, 10); hold(1, 132);
    expect_run(1, 6); expect_run(0, 128);
    drain("R6 inverted input");
    wr(3'd0, 24'h0);
    wr(3'd1, 24'h0);
    ir_in = 1'b0;
    repeat (4) @(negedge clk);
    wr(3'd4, 24'h0000FF);

    // R12 wrong mode bits, then missing receive enable
    wr(3'd0, 24'h000013);
    hold(1, 20); hold(0, 10);
    rd(3'd4, d); check("R12 mode not selected", 32'(d), 0);
    wr(3'd0, 24'h000031);
    hold(1, 20); hold(0, 10);
    rd(3'd4, d); check("R12 receive disabled", 32'(d), 0);
    wr(3'd0, 24'h000033);

    // R8 overflow: 20 bytes into a 16-deep queue
    wr(3'd5, scfg(0, 0, 0, 0, 0));
    wr(3'd3, 24'h000001);
    wr(3'd4, 24'h0000FF);
    for (int k = 0; k < 10; k++) begin
      hold(1, 2); hold(0, 2);
    end
    hold(0, 130);
    expect_run(1, 1);
    for (int k = 0; k < 9; k++) begin
      expect_run(0, 2); expect_run(1, 2);
    end
    expect_run(0, 128);
    rd(3'd4, d); check("R8 overflow flag", 32'(d[0]), 1);
    check("R11 irq from overflow", 32'(irq), 1);
    wr(3'd3, 24'h0);
    check("R11 irq masked", 32'(irq), 0);
    drain("R8 R7 full queue keeps first bytes");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule